// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block sends one management frame to a PHY over a two-wire management interface (MDC clock, bidirectional MDIO data). Software writes a packed 32-bit frame word into the frame register. If the controller is idle and the management port is enabled, that write starts the operation. The controller sends a run of preamble ones, then the frame word with its most significant bit first. For a read, it releases the data line at the turnaround and captures the 16 bits the PHY returns.

Software polls the idle flag to learn when a frame is done. After a read completes, the returned data sits in the low half of the frame register, and the header bits stay as written. MDC is produced from the system clock through a selectable divisor. It runs only while the port enable is set.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: A started frame puts exactly 64 bits on the line. The first 32 are ones (preamble). The rest are the frame word from bit 31 down to bit 0. The frame word fields are: [31:30] start code, [29:28] operation, [27:23] PHY address, [22:18] register address, [17:16] turnaround, [15:0] data.
- R2: A one-cycle `wr_en` pulse is accepted when `idle` is high and `port_en` is high. The word is stored in `frame_q`, and `idle` reads low from the next cycle.
- R3: A `wr_en` pulse while `idle` is low has no effect. The frame register and the bits sent are unchanged.
- R4: While `port_en` is low, `mdc` is held low and `wr_en` has no effect: `idle` stays high and `frame_q` keeps its value.
- R5: `div_sel` values 0, 1, 2 and 3 give an MDC period of 8, 16, 32 and 64 system clocks. After `port_en` rises, MDC is low for the first half-period and high for the second half.
- R6: During a frame, `mdio_o` changes only on an MDC falling edge. Read data is sampled on MDC rising edges.
- R7: A frame whose operation field is 2'b10 is a read. For a read, `mdio_oe` is low for the last 18 bit times, covering the turnaround and the data. For any other operation, `mdio_oe` is high for all 64 bit times.
- R8: When a read completes, the 16 sampled bits replace `frame_q[15:0]`, with the first bit sampled landing in bit 15. `frame_q[31:16]` keeps the written value.
- R9: `idle` rises on the same clock edge as the MDC falling edge that ends the 64th bit.
- R10: Dropping `port_en` during a frame aborts it. From the next cycle, `idle` is high and `mdio_oe` is low.
- R11: After reset, `idle` is high, `mdc` and `mdio_oe` are low, and `frame_q` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Management port enable; gates MDC and frame issue |
| div_sel | input | 2 | MDC divisor select (8, 16, 32, 64) |
| wr_en | input | 1 | Frame register write strobe |
| wr_data | input | 32 | Frame word to write |
| frame_q | output | 32 | Frame register contents, read data merged after a read |
| idle | output | 1 | High when no frame is in progress |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in from the PHY |

## Verification
Two functions can land in the same clock edge:
- The end of a read, when captured data is merged into the frame register.
- A new register write from software.

The bench provokes this by writing a different word in the middle of a read frame, and by polling right at completion. It then judges that the header half of the register survives while the low half takes the PHY's reply. The other coincidence is the edge where MDC falls and the frame ends. There the bench checks that `idle` rises on exactly that edge, against a behavioural MDC model compared every clock.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  localparam int FRAME_W = 32;
  localparam int DATA_W  = 16;
  localparam int PRE_W   = 32;

  localparam int OP_HI = 29;
  localparam int OP_LO = 28;

  localparam logic [1:0] OP_READ = 2'b10;

  // MDC period in system clocks for a given select value
  function automatic int unsigned div_period(input logic [1:0] sel, input int unsigned base);
    return base << sel;
  endfunction

  function automatic logic frame_is_read(input logic [FRAME_W-1:0] f);
    return f[OP_HI:OP_LO] == OP_READ;
  endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int BASE_DIV = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] div_sel,
  output logic       mdc,
  output logic       rise_tick,
  output logic       fall_tick
);
  localparam int CNT_W = $clog2(BASE_DIV * 8);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last_cnt;
  logic [CNT_W-1:0] half_cnt;

  always_comb begin
    last_cnt = CNT_W'(mdio_mgmt_pkg::div_period(div_sel, BASE_DIV) - 1);
    half_cnt = CNT_W'(mdio_mgmt_pkg::div_period(div_sel, BASE_DIV) / 2 - 1);
  end

  assign rise_tick = en && (cnt == half_cnt);
  assign fall_tick = en && (cnt == last_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!en) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else begin
      cnt <= (cnt >= last_cnt) ? '0 : cnt + 1'b1;
      if (rise_tick)      mdc <= 1'b1;
      else if (fall_tick) mdc <= 1'b0;
    end
  end

  // R4: clock parked low whenever the port is disabled
  assert_mdc_parked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !mdc);

endmodule

// File: rtl/mdio_bit_engine.sv
module mdio_bit_engine #(
  parameter int PRE_BITS = 32,
  parameter int FRAME_W  = 32,
  parameter int DATA_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic               rise_tick,
  input  logic               fall_tick,
  input  logic               mdio_i,
  output logic               busy,
  output logic               is_read,
  output logic               mdio_o,
  output logic               mdio_oe,
  output logic [DATA_W-1:0]  rd_data,
  output logic               done_tick,
  output logic               cap_tick
);
  localparam int TOT    = PRE_BITS + FRAME_W;
  localparam int IDX_W  = $clog2(TOT + 2);
  localparam int TA_POS = TOT - DATA_W - 2;
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(TOT);
  localparam logic [IDX_W-1:0] TA_IDX    = IDX_W'(TA_POS);
  localparam logic [IDX_W-1:0] DATA_IDX  = IDX_W'(TA_POS + 3);

  logic [TOT-1:0]    sh;
  logic [IDX_W-1:0]  idx;   // 0: waiting for first fall; k: bit k-1 on the line
  logic [DATA_W-1:0] cap;

  assign done_tick = busy && fall_tick && (idx == LAST_IDX);
  assign cap_tick  = busy && is_read && rise_tick && (idx >= DATA_IDX);
  assign mdio_o    = busy ? sh[TOT-1] : 1'b1;
  assign mdio_oe   = busy && (idx != '0) && !(is_read && (idx > TA_IDX));
  assign rd_data   = cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '1;
      idx     <= '0;
      busy    <= 1'b0;
      is_read <= 1'b0;
    end else if (!en) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (start && !busy) begin
      sh      <= {{PRE_BITS{1'b1}}, frame_in};
      idx     <= '0;
      busy    <= 1'b1;
      is_read <= mdio_mgmt_pkg::frame_is_read(frame_in);
    end else if (busy && fall_tick) begin
      if (idx == LAST_IDX) begin
        busy <= 1'b0;
        idx  <= '0;
      end else begin
        if (idx != '0) sh <= sh << 1;
        idx <= idx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cap <= '0;
    else if (cap_tick) cap <= {cap[DATA_W-2:0], mdio_i};
  end

  // R6: line data moves only right after an MDC falling tick
  assert_data_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && !$stable(mdio_o) |-> $past(fall_tick));

  // R7: never sample while this side is driving the line
  assert_no_drive_while_sampling_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_tick |-> !mdio_oe);

  // R9: completion always leaves the engine idle
  assert_done_goes_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_tick |=> !busy);

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl #(
  parameter int BASE_DIV = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        port_en,
  input  logic [1:0]  div_sel,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] frame_q,
  output logic        idle,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  import mdio_mgmt_pkg::*;

  logic rise_tick, fall_tick;
  logic busy, is_read, done_tick, cap_tick;
  logic accept, rd_done;
  logic [DATA_W-1:0] rd_data;

  assign accept  = wr_en && port_en && !busy;
  assign rd_done = done_tick && is_read;
  assign idle    = !busy;

  mdio_mdc_gen #(.BASE_DIV(BASE_DIV)) u_clk (
    .clk(clk), .rst_n(rst_n), .en(port_en), .div_sel(div_sel),
    .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_bit_engine #(.PRE_BITS(PRE_W), .FRAME_W(FRAME_W), .DATA_W(DATA_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .en(port_en), .start(accept), .frame_in(wr_data),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
    .busy(busy), .is_read(is_read), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .rd_data(rd_data), .done_tick(done_tick), .cap_tick(cap_tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       frame_q <= '0;
    else if (accept)  frame_q <= wr_data;
    else if (rd_done) frame_q[DATA_W-1:0] <= rd_data;
  end

  // R10: a disabled port never leaves a frame in flight
  assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> idle);

  // R3: writes during a frame leave the register untouched
  assert_busy_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !idle && !rd_done |=> $stable(frame_q));

  // R8: header half survives read completion
  assert_header_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> frame_q[31:16] == $past(frame_q[31:16]));

endmodule

// File: tb/mdio_mgmt_ctrl_test.sv
module mdio_mgmt_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, port_en = 1'b0, wr_en = 1'b0, mdio_i = 1'b1;
  logic [1:0]  div_sel = 2'd0;
  logic [31:0] wr_data = '0;
  wire  [31:0] frame_q;
  wire idle, mdc, mdio_o, mdio_oe;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_mgmt_ctrl uut (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .div_sel(div_sel),
    .wr_en(wr_en), .wr_data(wr_data), .frame_q(frame_q), .idle(idle),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural MDC model: enabled edges since port_en went high
  int k;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) k <= 0;
    else if (!port_en) k <= 0;
    else k <= k + 1;

  always @(negedge clk) if (rst_n) begin
    int n;
    n = 8 << div_sel;
    // R5 / R4: mdc follows the half-period model every clock
    chk(mdc === ((k % n) >= n / 2), "R5", "mdc", 64'(mdc), 64'((k % n) >= n / 2));
  end

  // PHY-side monitor
  bit prev_mdc = 0, prev_idle = 1, prev_o = 1, armed = 0;
  int nrise = 0;
  logic [63:0] seen_o, seen_oe;
  logic [15:0] resp = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!prev_idle && !idle && mdio_o !== prev_o)
        chk(prev_mdc && !mdc, "R6", "mdio_o moved off a falling edge", 64'(mdc), 64'(0));
      if (!prev_idle && !idle && prev_mdc && !mdc) begin
        armed = 1;
        if (nrise >= 48 && nrise < 64) mdio_i = resp[63 - nrise];
        else mdio_i = 1'b1;
      end
      if (armed && !prev_mdc && mdc && nrise < 64) begin
        seen_o[63 - nrise]  = mdio_o;
        seen_oe[63 - nrise] = mdio_oe;
        nrise++;
      end
      if (idle) armed = 0;
    end
    prev_mdc = mdc; prev_idle = idle; prev_o = mdio_o;
  end

  task automatic write_word(input logic [31:0] w);
    @(negedge clk); #1; wr_data = w; wr_en = 1'b1;
    @(negedge clk); #1; wr_en = 1'b0;
  endtask

  task automatic set_div(input logic [1:0] s);
    @(negedge clk); #1; port_en = 1'b0;
    @(negedge clk); #1; div_sel = s;
    @(negedge clk); #1; port_en = 1'b1;
  endtask

  task automatic run_frame(input logic [31:0] f, input logic [15:0] r, input bit poke);
    bit rd, pm;
    int cyc;
    logic [63:0] exp_bits, exp_oe, mask;
    rd = (f[29:28] == 2'b10);
    nrise = 0; resp = r; seen_o = '0; seen_oe = '0;
    write_word(f);
    chk(idle === 1'b0, "R2", "idle after accept", 64'(idle), 64'(0));
    chk(frame_q === f, "R2", "frame_q after accept", 64'(frame_q), 64'(f));
    if (poke) begin
      repeat (40) @(negedge clk);
      write_word(~f);
      chk(frame_q === f, "R3", "frame_q after busy write", 64'(frame_q), 64'(f));
    end
    cyc = 0; pm = mdc;
    while (idle !== 1'b1 && cyc < 20000) begin
      @(negedge clk); #1;
      if (idle === 1'b1)
        chk(pm && !mdc, "R9", "idle rise aligned to mdc fall", {pm, mdc}, 64'h2);
      pm = mdc; cyc++;
    end
    chk(cyc < 20000, "R9", "frame completes", 64'(cyc), 64'(20000));
    chk(nrise == 64, "R1", "bit count", 64'(nrise), 64'd64);
    exp_bits = {32'hFFFF_FFFF, f};
    mask = rd ? {{46{1'b1}}, 18'd0} : '1;
    exp_oe = mask;
    chk((seen_o & mask) === (exp_bits & mask), "R1", "serial bits", seen_o & mask, exp_bits & mask);
    chk(seen_oe === exp_oe, "R7", "output enable pattern", seen_oe, exp_oe);
    chk(frame_q === (rd ? {f[31:16], r} : f), "R8", "frame_q after frame",
        64'(frame_q), 64'(rd ? {f[31:16], r} : f));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] wf, rf, rf2, wf2;
    wf  = {2'b01, 2'b01, 5'd5,  5'd3,  2'b10, 16'hA5C3};
    rf  = {2'b01, 2'b10, 5'd17, 5'd1,  2'b10, 16'h0000};
    rf2 = {2'b01, 2'b10, 5'd31, 5'd30, 2'b10, 16'hFFFF};
    wf2 = {2'b01, 2'b01, 5'd0,  5'd31, 2'b10, 16'h0F0F};
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(idle === 1'b1, "R11", "idle", 64'(idle), 64'(1));
    chk(mdc === 1'b0 && mdio_oe === 1'b0, "R11", "mdc/oe", {mdc, mdio_oe}, 64'(0));
    chk(frame_q === '0, "R11", "frame_q", 64'(frame_q), 64'(0));
    #1 rst_n = 1'b1;

    // R4: write with port disabled is ignored
    write_word(wf);
    chk(idle === 1'b1, "R4", "idle with port off", 64'(idle), 64'(1));
    chk(frame_q === '0, "R4", "frame_q with port off", 64'(frame_q), 64'(0));

    set_div(2'd0);
    run_frame(wf, 16'h0, 1'b0);
    set_div(2'd1);
    run_frame(rf, 16'hBEEF, 1'b0);
    set_div(2'd2);
    run_frame(rf2, 16'h3C5A, 1'b1);   // R3 busy write during a read
    set_div(2'd3);
    run_frame(wf2, 16'h0, 1'b1);

    // R10: abort mid-frame
    set_div(2'd0);
    write_word(wf2);
    repeat (100) @(negedge clk);
    #1 port_en = 1'b0;
    @(negedge clk); #1;
    chk(idle === 1'b1, "R10", "idle after abort", 64'(idle), 64'(1));
    chk(mdio_oe === 1'b0, "R10", "oe after abort", 64'(mdio_oe), 64'(0));
    repeat (4) @(negedge clk);
    #1 port_en = 1'b1;
    run_frame(wf, 16'h0, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule